// File: doc/BRIEF.md
# Sixteen-Bit Slice ALU with Latched Carry

This block is a 16-bit arithmetic/logic unit. It is built from four cascaded 4-bit function slices. Each slice implements the complete set of sixteen arithmetic and sixteen logic functions chosen by four select lines and a mode bit. A small function decoder turns a 4-bit microcode function field into the slice controls: select lines, mode bit and the carry into the lowest slice. Carries pass between slices in active-low form. The carry leaving bit 15 is therefore low when a carry occurs.

The result is presented combinationally on every cycle. A microinstruction sets its load strobe to keep the result. On that clock edge the result is copied into a result register, and a one-bit carry register is written. For an arithmetic function the carry register takes the true carry, which is the inverse of the active-low slice output. For a logic function it takes zero. No other operation changes either register.

Top module: `alu16_lcarry`

## Requirements
- R1: Arithmetic function codes on `alu_fn` give these results modulo 2^16: 5 = A+B, 6 = A+B+1, 7 = A-B, 8 = A-B-1, 9 = A+1, 10 = A-1, 13 = A+A.
- R2: Logic function codes on `alu_fn` give: 0 = A, 1 = B, 2 = A AND B, 3 = A OR B, 4 = A XOR B, 11 = A AND NOT B, 12 = NOT A, 14 = A XNOR B, 15 = all zeros.
- R3: `alu_out` reflects the current operands and function code within the same cycle, with no register in the path.
- R4: On a rising edge with `load_l` = 1 and an arithmetic code, `carry_q` becomes 1 exactly when the 17-bit sum of the code's two addends and its carry-in exceeds 16 bits. Examples: 7 sets it when A >= B unsigned, and 10 sets it when A != 0.
- R5: On a rising edge with `load_l` = 1 and a logic code, `carry_q` becomes 0 whatever the operands.
- R6: On a rising edge with `load_l` = 1, `result_q` takes the value `alu_out` had before that edge.
- R7: On a rising edge with `load_l` = 0, `carry_q` and `result_q` keep their values.
- R8: A rising edge with `rst` = 1 clears `carry_q` and `result_q`, even when `load_l` = 1.
- R9: A carry generated in one 4-bit slice passes correctly through every higher slice. For example, 0x0FFF+1 gives 0x1000, and 0xFFFF+1 gives 0 with the carry set.
- R10: Codes 6, 7 and 9 inject a carry into bit 0, and codes 5, 8, 10 and 13 do not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| opnd_a | input | 16 | Operand A |
| opnd_b | input | 16 | Operand B |
| alu_fn | input | 4 | Microcode function code |
| load_l | input | 1 | Load strobe for carry and result registers |
| alu_out | output | 16 | Combinational result |
| carry_q | output | 1 | Registered true carry (0 after logic loads) |
| result_q | output | 16 | Registered result |

## Verification
The bench targets the polarity of the carry register. If the design latched the raw active-low slice carry, ADD with no overflow would show a set carry, and A-B with A >= B would show it clear. Logic functions are loaded with operands that would generate a carry in arithmetic mode. A design that did not force zero would then leave the carry set. Ripple patterns such as 0x0FFF+1 and 0xFFFF+1 expose a broken chain between slices as wrong upper nibbles. Cycles with the load strobe low, and a reset taken while the strobe is high, show whether the registers update when they must not.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

    localparam int FN_W  = 4;
    localparam int SEL_W = 4;

    typedef enum logic [FN_W-1:0] {
        FN_PASS_A = 4'd0,
        FN_PASS_B = 4'd1,
        FN_AND    = 4'd2,
        FN_OR     = 4'd3,
        FN_XOR    = 4'd4,
        FN_ADD    = 4'd5,
        FN_ADD1   = 4'd6,
        FN_SUB    = 4'd7,
        FN_SUBM1  = 4'd8,
        FN_INC    = 4'd9,
        FN_DEC    = 4'd10,
        FN_ANDN   = 4'd11,
        FN_NOT_A  = 4'd12,
        FN_DBL    = 4'd13,
        FN_XNOR   = 4'd14,
        FN_ZERO   = 4'd15
    } alu_fn_e;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             logic_mode;
        logic             cin_n;
    } slice_ctrl_t;

endpackage

// File: rtl/alu_fn_decode.sv
module alu_fn_decode
    import alu16_pkg::*;
(
    input  logic [FN_W-1:0] fn,
    output slice_ctrl_t     ctrl
);

    function automatic slice_ctrl_t mk(input logic [SEL_W-1:0] s,
                                       input logic m, input logic cn);
        slice_ctrl_t c;
        c.sel        = s;
        c.logic_mode = m;
        c.cin_n      = cn;
        return c;
    endfunction

    always_comb begin
        case (alu_fn_e'(fn))
            FN_PASS_A: ctrl = mk(4'b1111, 1'b1, 1'b1);
            FN_PASS_B: ctrl = mk(4'b1010, 1'b1, 1'b1);
            FN_AND:    ctrl = mk(4'b1011, 1'b1, 1'b1);
            FN_OR:     ctrl = mk(4'b1110, 1'b1, 1'b1);
            FN_XOR:    ctrl = mk(4'b0110, 1'b1, 1'b1);
            FN_ADD:    ctrl = mk(4'b1001, 1'b0, 1'b1);
            FN_ADD1:   ctrl = mk(4'b1001, 1'b0, 1'b0);
            FN_SUB:    ctrl = mk(4'b0110, 1'b0, 1'b0);
            FN_SUBM1:  ctrl = mk(4'b0110, 1'b0, 1'b1);
            FN_INC:    ctrl = mk(4'b0000, 1'b0, 1'b0);
            FN_DEC:    ctrl = mk(4'b1111, 1'b0, 1'b1);
            FN_ANDN:   ctrl = mk(4'b0111, 1'b1, 1'b1);
            FN_NOT_A:  ctrl = mk(4'b0000, 1'b1, 1'b1);
            FN_DBL:    ctrl = mk(4'b1100, 1'b0, 1'b1);
            FN_XNOR:   ctrl = mk(4'b1001, 1'b1, 1'b1);
            FN_ZERO:   ctrl = mk(4'b0011, 1'b1, 1'b1);
            default:   ctrl = mk(4'b0011, 1'b1, 1'b1);
        endcase
    end

endmodule

// File: rtl/alu_slice.sv
// One function slice: sixteen arithmetic and sixteen logic functions
// selected by sel/logic_mode; carry in and carry out are active low.
module alu_slice
    import alu16_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0]     a,
    input  logic [W-1:0]     b,
    input  logic [SEL_W-1:0] sel,
    input  logic             logic_mode,
    input  logic             cin_n,
    output logic [W-1:0]     f,
    output logic             cout_n
);

    logic [W-1:0] prop;   // first addend term, superset of gen
    logic [W-1:0] gen;    // second addend term
    logic [W-1:0] half;
    logic [W:0]   cy;     // active-high internal carries

    always_comb begin
        prop = a | (b & {W{sel[0]}}) | (~b & {W{sel[1]}});
        gen  = a & ((b & {W{sel[3]}}) | (~b & {W{sel[2]}}));
        half = prop ^ gen;
        cy[0] = ~cin_n;
        for (int i = 0; i < W; i++) begin
            cy[i+1] = gen[i] | (prop[i] & cy[i]);
        end
        f      = logic_mode ? ~half : (half ^ cy[W-1:0]);
        cout_n = ~cy[W];
    end

endmodule

// File: rtl/alu16_lcarry.sv
module alu16_lcarry
    import alu16_pkg::*;
#(
    parameter int WIDTH   = 16,
    parameter int SLICE_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic [FN_W-1:0]  alu_fn,
    input  logic             load_l,
    output logic [WIDTH-1:0] alu_out,
    output logic             carry_q,
    output logic [WIDTH-1:0] result_q
);

    localparam int NSLICE = WIDTH / SLICE_W;

    typedef struct packed {
        logic             carry;
        logic [WIDTH-1:0] result;
    } state_t;

    slice_ctrl_t   ctrl;
    logic [NSLICE:0] carry_n;   // active-low ripple chain
    state_t        st_d, st_q;

    alu_fn_decode u_dec (
        .fn   (alu_fn),
        .ctrl (ctrl)
    );

    assign carry_n[0] = ctrl.cin_n;

    for (genvar k = 0; k < NSLICE; k++) begin : g_slice
        alu_slice #(.W(SLICE_W)) u_slice (
            .a          (opnd_a[k*SLICE_W +: SLICE_W]),
            .b          (opnd_b[k*SLICE_W +: SLICE_W]),
            .sel        (ctrl.sel),
            .logic_mode (ctrl.logic_mode),
            .cin_n      (carry_n[k]),
            .f          (alu_out[k*SLICE_W +: SLICE_W]),
            .cout_n     (carry_n[k+1])
        );
    end

    always_comb begin
        st_d = st_q;
        if (load_l) begin
            st_d.result = alu_out;
            st_d.carry  = ctrl.logic_mode ? 1'b0 : ~carry_n[NSLICE];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign carry_q  = st_q.carry;
    assign result_q = st_q.result;

endmodule

// File: rtl/alu16_lcarry_chk.sv
module alu16_lcarry_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         load_l,
    input logic [W-1:0] alu_out,
    input logic         carry_q,
    input logic [W-1:0] result_q,
    input logic         logic_mode,
    input logic         top_cout_n
);

    // R8
    p_reset_clears_r8: assert property (@(posedge clk)
        rst |=> (carry_q == 1'b0 && result_q == '0));

    // R7
    p_hold_no_load_r7: assert property (@(posedge clk) disable iff (rst)
        !load_l |=> ($stable(carry_q) && $stable(result_q)));

    // R6
    p_result_capture_r6: assert property (@(posedge clk) disable iff (rst)
        load_l |=> (result_q == $past(alu_out)));

    // R5
    p_logic_carry_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (load_l && logic_mode) |=> (carry_q == 1'b0));

    // R4
    p_arith_carry_true_r4: assert property (@(posedge clk) disable iff (rst)
        (load_l && !logic_mode) |=> (carry_q == !$past(top_cout_n)));

endmodule

bind alu16_lcarry alu16_lcarry_chk #(.W(WIDTH)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .load_l     (load_l),
    .alu_out    (alu_out),
    .carry_q    (carry_q),
    .result_q   (result_q),
    .logic_mode (ctrl.logic_mode),
    .top_cout_n (carry_n[NSLICE])
);

// File: tb/alu16_lcarry_tb_top.sv
module alu16_lcarry_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] opnd_a = '0;
    logic [15:0] opnd_b = '0;
    logic [3:0]  alu_fn = '0;
    logic        load_l = 1'b0;
    logic [15:0] alu_out;
    logic        carry_q;
    logic [15:0] result_q;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #5 clk = ~clk;

    alu16_lcarry dut_i (
        .clk(clk), .rst(rst), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .alu_fn(alu_fn), .load_l(load_l), .alu_out(alu_out),
        .carry_q(carry_q), .result_q(result_q)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // reference model built from R1/R2/R4/R10
    task automatic ref_calc(input logic [3:0] fn, input logic [15:0] a, input logic [15:0] b,
                            output logic [15:0] r, output logic c);
        logic [16:0] s;
        logic [15:0] x, y;
        logic        ci;
        bit          arith;
        arith = 1; x = a; y = '0; ci = 0;
        case (fn)
            4'd5:  begin y = b; end
            4'd6:  begin y = b; ci = 1; end
            4'd7:  begin y = ~b; ci = 1; end
            4'd8:  begin y = ~b; end
            4'd9:  begin ci = 1; end
            4'd10: begin y = 16'hFFFF; end
            4'd13: begin y = a; end
            default: arith = 0;
        endcase
        if (arith) begin
            s = {1'b0, x} + {1'b0, y} + {16'd0, ci};
            r = s[15:0];
            c = s[16];
        end else begin
            c = 0;
            case (fn)
                4'd0:  r = a;
                4'd1:  r = b;
                4'd2:  r = a & b;
                4'd3:  r = a | b;
                4'd4:  r = a ^ b;
                4'd11: r = a & ~b;
                4'd12: r = ~a;
                4'd14: r = ~(a ^ b);
                default: r = '0;
            endcase
        end
    endtask

    // one loaded operation: check comb output, then registers after the edge
    task automatic run_op(input string req, input logic [3:0] fn,
                          input logic [15:0] a, input logic [15:0] b);
        logic [15:0] er;
        logic        ec;
        ref_calc(fn, a, b, er, ec);
        @(negedge clk);
        alu_fn = fn; opnd_a = a; opnd_b = b; load_l = 1'b1;
        #1;
        chk({req, " R3 comb"}, alu_out, er);
        @(posedge clk); #1;
        chk({req, " R6 result_q"}, result_q, er);
        chk({req, " carry_q"}, {15'd0, carry_q}, {15'd0, ec});
        load_l = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1;
        chk("R8 reset carry", {15'd0, carry_q}, 16'd0);
        chk("R8 reset result", result_q, 16'd0);
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic t_arith_random();
        logic [3:0] codes [7] = '{4'd5, 4'd6, 4'd7, 4'd8, 4'd9, 4'd10, 4'd13};
        for (int i = 0; i < 7; i++) begin
            for (int n = 0; n < 12; n++) begin
                run_op("R1 R4", codes[i], 16'($urandom), 16'($urandom));
            end
        end
        run_op("R4 sub equal", 4'd7, 16'h1234, 16'h1234);
        run_op("R4 sub less", 4'd7, 16'h0001, 16'h0002);
        run_op("R4 dec zero", 4'd10, 16'h0000, 16'h0000);
        run_op("R4 add no carry", 4'd5, 16'h0100, 16'h0200);
    endtask

    task automatic t_logic();
        logic [3:0] codes [9] = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd11, 4'd12, 4'd14, 4'd15};
        for (int i = 0; i < 9; i++) begin
            // prime carry to 1, then a logic load must clear it
            run_op("R4 prime", 4'd5, 16'hFFFF, 16'hFFFF);
            run_op("R2 R5", codes[i], 16'hFFFF, 16'hFFFF);
            for (int n = 0; n < 6; n++) begin
                run_op("R2 R5", codes[i], 16'($urandom), 16'($urandom));
            end
        end
    endtask

    task automatic t_ripple();
        run_op("R9 nib0", 4'd9, 16'h000F, 16'h0000);
        run_op("R9 nib1", 4'd9, 16'h00FF, 16'h0000);
        run_op("R9 nib2", 4'd9, 16'h0FFF, 16'h0000);
        run_op("R9 wrap", 4'd9, 16'hFFFF, 16'h0000);
        run_op("R9 add wrap", 4'd5, 16'h8000, 16'h8000);
        run_op("R10 add1", 4'd6, 16'hFFFE, 16'h0001);
        run_op("R10 add", 4'd5, 16'hFFFE, 16'h0001);
        run_op("R10 subm1", 4'd8, 16'h0005, 16'h0005);
        run_op("R10 dbl", 4'd13, 16'h7FFF, 16'h0000);
    endtask

    task automatic t_hold();
        run_op("R7 setup", 4'd5, 16'hC000, 16'h4001);  // result 0x0001, carry 1
        @(negedge clk);
        alu_fn = 4'd15; opnd_a = 16'h5555; opnd_b = 16'hAAAA; load_l = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R7 hold result", result_q, 16'h0001);
        chk("R7 hold carry", {15'd0, carry_q}, 16'd1);
        chk("R3 comb no load", alu_out, 16'h0000);
    endtask

    task automatic t_reset_with_load();
        run_op("R8 setup", 4'd5, 16'hFFFF, 16'h0003);
        @(negedge clk);
        rst = 1'b1; load_l = 1'b1; alu_fn = 4'd5; opnd_a = 16'hFFFF; opnd_b = 16'hFFFF;
        @(posedge clk); #1;
        chk("R8 reset over load carry", {15'd0, carry_q}, 16'd0);
        chk("R8 reset over load result", result_q, 16'd0);
        @(negedge clk); rst = 1'b0; load_l = 1'b0;
    endtask

    initial begin
        repeat (2) @(posedge clk);
        t_reset();
        t_arith_random();
        t_logic();
        t_ripple();
        t_hold();
        t_reset_with_load();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++; failures++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule